// File: doc/BRIEF.md
# Stack-Relative Halfword Store Unit

This unit executes one instruction from a 16-bit instruction stream: a store of a register's lower halfword to memory at an address formed from the stack pointer plus a displacement. Instruction words arrive on a valid/ready stream. A word moves only in a cycle where `in_valid` and `in_ready` are both high. While a store is executing, `in_ready` is low. The upstream source must then hold its word, or withdraw it. Words offered during that time are not consumed and have no effect.

Up to two extension prefix words may come before the store. Each prefix carries a 13-bit immediate that widens the displacement. Without a prefix, the store's 6-bit field counts halfwords and is doubled. With one prefix, the displacement is a sign-extended 19-bit byte offset. With two prefixes, it is a full 32-bit byte offset. Any other accepted non-prefix instruction discards the collected prefixes.

A store takes two cycles. In the first cycle the unit reads the source register through its register-file port. In the second cycle it drives a single-cycle halfword write with both byte enables set.

Top module: `sps_store_unit`

## Requirements
- R1: An accepted word whose bits 15:10 equal 6'b010110 is a store: bits 9:4 form the 6-bit field `f` and bits 3:0 name the source register r0..r15.
- R2: A store with no preceding prefix writes to `sp + 2*f`, with `f` zero-extended, so the lowest address offset bit is 0.
- R3: A word with bits 15:13 equal 3'b110 is a prefix carrying a 13-bit immediate in bits 12:0. After one prefix `a`, the store writes to `sp + sext32({a, f})`, a 19-bit displacement used without doubling.
- R4: After two prefixes `a` then `b`, the store writes to `sp + {a, b, f}`, a 32-bit displacement used without doubling.
- R5: The prefix count saturates at two. A third or later prefix before a store is ignored, so the first two prefixes still form the displacement.
- R6: An accepted instruction that is neither a prefix nor a store clears the collected prefixes and produces no memory write.
- R7: The write data is bits 15:0 of the source register. During the first execution cycle `rf_sel` presents that register's index.
- R8: After a store is accepted, `busy` is high for exactly two cycles. `mem_we` is high only in the second of those cycles, for one cycle, with `mem_be` equal to 2'b11.
- R9: `in_ready` is low while `busy` is high. A word offered in that time is not taken and does not change the following store.
- R10: After reset, `busy` and `mem_we` are low, `in_ready` is high and no prefix is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_word | input | 16 | Instruction word |
| sp | input | 32 | Current stack pointer, sampled when the store is taken |
| rf_sel | output | 4 | Register-file read index |
| rf_data | input | 32 | Register-file read data for `rf_sel`, same cycle |
| busy | output | 1 | Store executing |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_be | output | 2 | Byte enables of the halfword write |
| mem_addr | output | 32 | Write byte address |
| mem_data | output | 16 | Write halfword |

## Verification
The bench builds the unit at its default sizes: a 32-bit stack pointer and data path, sixteen registers and 13-bit prefix immediates. At these sizes the two-prefix displacement fills the whole address width. The same build reaches sign extension of a negative 19-bit offset, wrap-around of the address sum, the largest unscaled field, saturation after three prefixes, and a prefix offered while the unit is busy.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam logic [5:0] OP_STORE  = 6'b010110;
  localparam logic [2:0] OP_PREFIX = 3'b110;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } sps_state_e;
endpackage

// File: rtl/sps_prefix_acc.sv
module sps_prefix_acc #(
  parameter int PFX_W    = 13,
  parameter int PFX_SLOTS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_pfx,
  input  logic             drop_all,
  input  logic [PFX_W-1:0] pfx_imm,
  output logic [1:0]       pfx_cnt,
  output logic [PFX_W-1:0] pfx_val [PFX_SLOTS]
);
  logic [1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || drop_all) begin
      cnt_q <= '0;
    end else if (take_pfx && cnt_q < 2'(PFX_SLOTS)) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  for (genvar s = 0; s < PFX_SLOTS; s++) begin : g_slot
    logic [PFX_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (take_pfx && cnt_q == 2'(s)) begin
        slot_q <= pfx_imm;
      end
    end
    assign pfx_val[s] = slot_q;
  end

  assign pfx_cnt = cnt_q;
endmodule

// File: rtl/sps_disp_form.sv
module sps_disp_form #(
  parameter int XLEN    = 32,
  parameter int PFX_W   = 13,
  parameter int FIELD_W = 6
) (
  input  logic [1:0]         pfx_cnt,
  input  logic [PFX_W-1:0]   pfx_hi,
  input  logic [PFX_W-1:0]   pfx_lo,
  input  logic [FIELD_W-1:0] field,
  output logic [XLEN-1:0]    disp
);
  localparam int ONE_W = PFX_W + FIELD_W;
  localparam int TWO_W = 2 * PFX_W + FIELD_W;

  logic [ONE_W-1:0] one_raw;
  logic [TWO_W-1:0] two_raw;

  assign one_raw = {pfx_hi, field};
  assign two_raw = {pfx_hi, pfx_lo, field};

  always_comb begin
    unique case (pfx_cnt)
      2'd0:    disp = XLEN'({field, 1'b0});
      2'd1:    disp = XLEN'($signed(one_raw));
      default: disp = XLEN'(two_raw);
    endcase
  end
endmodule

// File: rtl/sps_seq.sv
module sps_seq
  import sps_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int HALF_W = 16,
  parameter int RS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [XLEN-1:0]   addr_in,
  input  logic [RS_W-1:0]   rs_in,
  input  logic [XLEN-1:0]   rf_data,
  output logic [RS_W-1:0]   rf_sel,
  output logic              idle,
  output logic              we,
  output logic [XLEN-1:0]   addr,
  output logic [HALF_W-1:0] data
);
  sps_state_e        state_q;
  logic [XLEN-1:0]   addr_q;
  logic [RS_W-1:0]   rs_q;
  logic [HALF_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rs_q    <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_READ;
          addr_q  <= addr_in;
          rs_q    <= rs_in;
        end
        ST_READ: begin
          state_q <= ST_WRITE;
          data_q  <= rf_data[HALF_W-1:0];
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rf_sel = rs_q;
  assign idle   = (state_q == ST_IDLE);
  assign we     = (state_q == ST_WRITE);
  assign addr   = addr_q;
  assign data   = data_q;
endmodule

// File: rtl/sps_store_unit.sv
module sps_store_unit
  import sps_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NREG    = 16,
  parameter int PFX_W   = 13,
  parameter int FIELD_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [15:0]              in_word,
  input  logic [XLEN-1:0]          sp,
  output logic [$clog2(NREG)-1:0]  rf_sel,
  input  logic [XLEN-1:0]          rf_data,
  output logic                     busy,
  output logic                     mem_we,
  output logic [1:0]               mem_be,
  output logic [XLEN-1:0]          mem_addr,
  output logic [15:0]              mem_data
);
  localparam int RS_W  = $clog2(NREG);
  localparam int SLOTS = 2;

  logic accept, is_pfx, is_store, idle;
  logic [1:0]         pfx_cnt;
  logic [PFX_W-1:0]   pfx_val [SLOTS];
  logic [XLEN-1:0]    disp;
  logic [FIELD_W-1:0] field;
  logic [RS_W-1:0]    rs_idx;

  assign accept   = in_valid && in_ready;
  assign is_pfx   = (in_word[15:13] == OP_PREFIX);
  assign is_store = (in_word[15:10] == OP_STORE);
  assign field    = in_word[RS_W +: FIELD_W];
  assign rs_idx   = in_word[RS_W-1:0];

  sps_prefix_acc #(.PFX_W(PFX_W), .PFX_SLOTS(SLOTS)) u_pfx (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_pfx (accept && is_pfx),
    .drop_all (accept && !is_pfx),
    .pfx_imm  (in_word[PFX_W-1:0]),
    .pfx_cnt  (pfx_cnt),
    .pfx_val  (pfx_val)
  );

  sps_disp_form #(.XLEN(XLEN), .PFX_W(PFX_W), .FIELD_W(FIELD_W)) u_disp (
    .pfx_cnt (pfx_cnt),
    .pfx_hi  (pfx_val[0]),
    .pfx_lo  (pfx_val[1]),
    .field   (field),
    .disp    (disp)
  );

  sps_seq #(.XLEN(XLEN), .HALF_W(16), .RS_W(RS_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept && is_store),
    .addr_in (sp + disp),
    .rs_in   (rs_idx),
    .rf_data (rf_data),
    .rf_sel  (rf_sel),
    .idle    (idle),
    .we      (mem_we),
    .addr    (mem_addr),
    .data    (mem_data)
  );

  assign in_ready = idle;
  assign busy     = !idle;
  assign mem_be   = mem_we ? 2'b11 : 2'b00;
endmodule

// File: rtl/sps_store_chk.sv
module sps_store_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [15:0]     in_word,
  input logic            busy,
  input logic            mem_we,
  input logic [1:0]      mem_be,
  input logic [XLEN-1:0] mem_addr,
  input logic [15:0]     mem_data,
  input logic [XLEN-1:0] rf_data
);
  logic take_store;
  assign take_store = in_valid && in_ready && (in_word[15:10] == 6'b010110);

  AST_STORE_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    take_store |=> busy && !mem_we); // R8
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_we |=> mem_we); // R8
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we && !busy); // R8
  AST_FULL_HALFWORD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_be == 2'b11); // R8
  AST_NO_TAKE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready); // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $stable(mem_addr)); // R2
  AST_DATA_FROM_REG: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_data == $past(rf_data[15:0])); // R7
endmodule

bind sps_store_unit sps_store_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_word  (in_word),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_be   (mem_be),
  .mem_addr (mem_addr),
  .mem_data (mem_data),
  .rf_data  (rf_data)
);

// File: tb/sim_sps_store_unit.sv
module sim_sps_store_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic [31:0] sp = '0;
  logic [3:0]  rf_sel;
  logic [31:0] rf_data;
  logic        busy, mem_we;
  logic [1:0]  mem_be;
  logic [31:0] mem_addr;
  logic [15:0] mem_data;

  int tests = 0;
  int fails = 0;
  logic [31:0] regs [16];
  logic [31:0] q_addr [$];
  logic [15:0] q_data [$];
  logic done = 0;

  always #5 clk = ~clk;
  assign rf_data = regs[rf_sel];

  sps_store_unit u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] st_w(input logic [5:0] f, input logic [3:0] rs);
    return {6'b010110, f, rs};
  endfunction
  function automatic logic [15:0] px_w(input logic [12:0] a);
    return {3'b110, a};
  endfunction

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_word = w;
    @(negedge clk);
    in_valid = 0; in_word = '0;
  endtask

  // driver: pushes expected write then issues the store
  task automatic store(input logic [5:0] f, input logic [3:0] rs, input logic [31:0] exp_a);
    q_addr.push_back(exp_a);
    q_data.push_back(regs[rs][15:0]);
    send(st_w(f, rs));
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (q_addr.size() == 0) begin
        chk("R6 unexpected write", 32'(mem_we), 32'd0);
      end else begin
        chk("R2/R3/R4 address", mem_addr, q_addr.pop_front());
        chk("R7 data", 32'(mem_data), 32'(q_data.pop_front()));
        chk("R8 byte enables", 32'(mem_be), 32'd3);
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'hC0DE_0000 | (32'(i) * 32'h1111) ^ 32'h0000_8421;
    repeat (3) @(negedge clk);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 mem_we", 32'(mem_we), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 in_ready", 32'(in_ready), 1);

    // R2 + R8 timing, R1 decode
    sp = 32'h0000_1000;
    store(6'h15, 4'd3, 32'h0000_1000 + 32'h2A);
    chk("R8 busy c1", 32'(busy), 1);
    chk("R8 no we c1", 32'(mem_we), 0);
    chk("R7 rf_sel", 32'(rf_sel), 3);
    chk("R9 ready low", 32'(in_ready), 0);
    @(negedge clk);
    chk("R8 busy c2", 32'(busy), 1);
    chk("R8 we c2", 32'(mem_we), 1);
    @(negedge clk);
    chk("R8 busy done", 32'(busy), 0);
    chk("R8 we done", 32'(mem_we), 0);

    // R2 largest field
    sp = 32'h2000_0000;
    store(6'h3F, 4'd15, 32'h2000_007E);

    // R3 one prefix, small example
    sp = 32'h0000_0100;
    send(px_w(13'h1));
    store(6'h02, 4'd0, 32'h0000_0142);

    // R3 negative sign extension
    sp = 32'h0010_0000;
    send(px_w(13'h1000));
    store(6'h04, 4'd7, 32'h0010_0000 + 32'hFFFC_0004);

    // R4 two prefixes with wrap
    sp = 32'hF000_0000;
    send(px_w(13'h1ABC));
    send(px_w(13'h0123));
    store(6'h08, 4'd9, 32'hF000_0000 + {13'h1ABC, 13'h0123, 6'h08});

    // R5 third prefix ignored
    sp = 32'h0000_4000;
    send(px_w(13'h0002));
    send(px_w(13'h0003));
    send(px_w(13'h1FFF));
    store(6'h06, 4'd5, 32'h0000_4000 + {13'h0002, 13'h0003, 6'h06});

    // R6 other instruction clears prefix, no write
    sp = 32'h0000_8000;
    send(px_w(13'h0777));
    send(16'h0000);
    repeat (3) @(negedge clk);
    chk("R6 no write after other", 32'(q_addr.size()), 0);
    store(6'h05, 4'd2, 32'h0000_800A);

    // R9 prefix offered while busy is not taken
    sp = 32'h0000_0040;
    store(6'h01, 4'd4, 32'h0000_0042);
    in_valid = 1; in_word = px_w(13'h0100);
    chk("R9 ready low with offer", 32'(in_ready), 0);
    @(negedge clk);
    in_valid = 0; in_word = '0;
    store(6'h03, 4'd6, 32'h0000_0046);

    repeat (4) @(negedge clk);
    chk("R8 queue drained", 32'(q_addr.size()), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule